// File: doc/BRIEF.md
# Parallel-Port to Asynchronous-Bus Transaction Bridge

This block turns a narrow host parallel port into a 68000-style bus master. The host picks an operation on a 3-bit command select. It then writes successive 16-bit words through one shared port: the low half of the address, the high half, and for stores a data word. Each word is taken on a falling edge of an active-low write strobe. Loads are started by an active-low read strobe. The loaded word is then driven back on the port for as long as that strobe stays low.

A single handshake output paces the host. During a store it is high while the bus cycle is running. During a load it goes high once the fetched word is ready. A side status register reports the encoded interrupt priority level and accepts a soft-reset bit that freezes the transaction sequencer. An active-low pending flag signals any nonzero interrupt level.

On the bus side the cycle is a request/acknowledge pair with active-low upper and lower data-strobe lane enables. Host strobes are assumed to be already synchronous to `clk`.

Top module: `hb_bridge`

## Requirements
- R1: After a synchronous reset, `host_rdy`=0, `bus_req`=0, `port_oe`=0, `bus_uds_n`=`bus_lds_n`=1 and `irq_pend_n`=1.
- R2: The command select codes are 000 word store, 001 word load, 010 byte store, 011 byte load and 100 status access. Codes 101 to 111 make every strobe have no effect.
- R3: The first write strobe of a transaction stores the low address half and the second stores the high half. `bus_addr` shows {high,low} and stays stable while `bus_req` is held.
- R4: For a store, the third write strobe stores the data word and raises `bus_req` and `host_rdy` on the clock edge that first samples the strobe low. No request is made before that strobe.
- R5: `bus_req` stays high until `bus_ack` is seen, then drops one cycle later. A store's `host_rdy` stays high until both `bus_ack` and `bus_req` are low.
- R6: For a load, `bus_req` rises only after a falling read strobe. `host_rdy` rises after the handshake ends. The full 16-bit bus word is then driven on `port_out` with `port_oe`=1 while `rd_n` is low. When `rd_n` returns high, `port_oe` drops at once and `host_rdy` drops on the next edge.
- R7: Lane enables are active low. A word access pulls both low. A byte access with address bit 0 = 0 pulls only `bus_uds_n` low, and with bit 0 = 1 pulls only `bus_lds_n` low. Both are high whenever `bus_req` is low. Store data passes to `bus_wdata` unchanged, so the host repeats an even-address byte on both lanes.
- R8: With command 100 and `rd_n` low, `port_out` carries the interrupt level sampled one clock earlier in bits 15:13, with all other bits 0.
- R9: A write strobe with command 100 copies port bit 0 into a soft-reset bit. While that bit is 1, the sequencer is held idle and no strobe starts a bus cycle. Writing 0 restores normal operation.
- R10: `irq_pend_n` is low one clock after `irq_level` is sampled nonzero, and high one clock after it is sampled zero.
- R11: A strobe in the wrong phase changes nothing. This covers a read strobe before the address is complete, and a write strobe while a load waits for its read strobe.
- R12: Any change of the command select, outside a running bus cycle, returns the sequencer to expecting the low address half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_sel | input | 3 | Operation select |
| port_in | input | 16 | Host word into the block |
| port_out | output | 16 | Word returned to the host |
| port_oe | output | 1 | High while the block drives the port |
| wr_n | input | 1 | Active-low host write strobe |
| rd_n | input | 1 | Active-low host read strobe |
| host_rdy | output | 1 | Store busy / load data ready handshake |
| irq_level | input | 3 | Encoded interrupt priority level |
| irq_pend_n | output | 1 | Active-low interrupt pending |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 16 | Bus store data |
| bus_rdata | input | 16 | Bus load data |
| bus_rw | output | 1 | 1 for a load, 0 for a store |
| bus_uds_n | output | 1 | Upper lane enable, active low |
| bus_lds_n | output | 1 | Lower lane enable, active low |
| bus_req | output | 1 | Bus cycle request |
| bus_ack | input | 1 | Bus cycle acknowledge |

## Verification
The bench targets the phase sequencer's ordering. A command change after a single address word must restart the sequence; a design that kept its phase would put the next word into the high half and issue a wrong address. Stray read strobes during address entry and stray write strobes while a load waits must leave the captured address intact; a leaky decoder would overwrite the high half or fire a bus cycle early. The handshake is checked from both sides: a bridge that dropped the host handshake when the acknowledge arrived, rather than after the request and acknowledge both fell, shows up as a premature ready change. A soft reset that failed to hold the sequencer would let a store reach the bus.

// File: rtl/hb_pkg.sv
// Shared command codes and sequencer phase type for the host-to-bus bridge.
package hb_pkg;
    localparam logic [2:0] CMD_WR16 = 3'b000;
    localparam logic [2:0] CMD_RD16 = 3'b001;
    localparam logic [2:0] CMD_WR8  = 3'b010;
    localparam logic [2:0] CMD_RD8  = 3'b011;
    localparam logic [2:0] CMD_STAT = 3'b100;

    typedef enum logic [2:0] {
        PH_ALO,   // expecting low address half
        PH_AHI,   // expecting high address half
        PH_DATA,  // expecting store data
        PH_RDW,   // load armed, waiting for read strobe
        PH_BUS,   // bus handshake in flight
        PH_RDH    // load word presented to host
    } phase_t;
endpackage

// File: rtl/hb_strobe_edge.sv
// Falling-edge detector for a set of active-low host strobes.
// Assumes the strobes are already synchronous to clk.
module hb_strobe_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strb_n,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_edge
        // Remember last sampled level of strobe g.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b1;
            else        prev_q[g] <= strb_n[g];
        end
        assign fall[g] = prev_q[g] & ~strb_n[g];
    end
endmodule

// File: rtl/hb_status_regs.sv
// Status side: samples the interrupt level, drives the pending flag and
// holds the soft-reset bit written by a status-command write strobe.
module hb_status_regs #(
    parameter int IPL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_cmd,
    input  logic             wr_fall,
    input  logic             soft_bit,
    input  logic [IPL_W-1:0] irq_level,
    output logic [IPL_W-1:0] ipl_q,
    output logic             irq_pend_n,
    output logic             soft_rst
);
    // Register the level and its pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipl_q      <= '0;
            irq_pend_n <= 1'b1;
        end else begin
            ipl_q      <= irq_level;
            irq_pend_n <= (irq_level == '0);
        end
    end

    // Capture the soft-reset bit on a status write.
    always_ff @(posedge clk) begin
        if (!rst_n)                    soft_rst <= 1'b0;
        else if (stat_cmd && wr_fall)  soft_rst <= soft_bit;
    end

    p_pend_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |=> !irq_pend_n);
    p_pend_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == '0) |=> irq_pend_n);
endmodule

// File: rtl/hb_txn_seq.sv
// Transaction sequencer: walks address-low, address-high, data or
// read-strobe phases, latches words, runs the request/acknowledge handshake
// and the host ready line. Assumes the host keeps cmd_sel steady during a
// bus cycle; rst_n here also carries the soft reset.
module hb_txn_seq
    import hb_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_sel,
    input  logic [DATA_W-1:0] port_in,
    input  logic              wr_fall,
    input  logic              rd_fall,
    input  logic              rd_n,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              rd_hold,
    output logic              host_rdy,
    output logic              bus_req,
    output logic              bus_rw,
    output logic              byte_op,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    phase_t            phase;
    logic [2:0]        cmd_q;
    logic [DATA_W-1:0] addr_lo, addr_hi;
    logic              cmd_chg, xfer_cmd;

    assign cmd_chg  = (cmd_sel != cmd_q);
    assign xfer_cmd = (cmd_sel <= CMD_RD8);
    assign addr     = {addr_hi, addr_lo};
    assign rd_hold  = (phase == PH_RDH);

    // Phase walk, word latching and bus handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_ALO;
            cmd_q    <= CMD_WR16;
            addr_lo  <= '0;
            addr_hi  <= '0;
            wdata    <= '0;
            rdata    <= '0;
            bus_req  <= 1'b0;
            host_rdy <= 1'b0;
            bus_rw   <= 1'b0;
            byte_op  <= 1'b0;
        end else begin
            cmd_q <= cmd_sel;
            unique case (phase)
                PH_ALO: begin
                    if (!cmd_chg && wr_fall && xfer_cmd) begin
                        addr_lo <= port_in;
                        phase   <= PH_AHI;
                    end
                end
                PH_AHI: begin
                    if (cmd_chg) phase <= PH_ALO;
                    else if (wr_fall) begin
                        addr_hi <= port_in;
                        phase   <= cmd_sel[0] ? PH_RDW : PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (cmd_chg) phase <= PH_ALO;
                    else if (wr_fall) begin
                        wdata    <= port_in;
                        bus_req  <= 1'b1;
                        host_rdy <= 1'b1;
                        bus_rw   <= 1'b0;
                        byte_op  <= cmd_sel[1];
                        phase    <= PH_BUS;
                    end
                end
                PH_RDW: begin
                    if (cmd_chg) phase <= PH_ALO;
                    else if (rd_fall) begin
                        bus_req <= 1'b1;
                        bus_rw  <= 1'b1;
                        byte_op <= cmd_sel[1];
                        phase   <= PH_BUS;
                    end
                end
                PH_BUS: begin
                    if (bus_req && bus_ack) begin
                        bus_req <= 1'b0;
                        if (bus_rw) rdata <= bus_rdata;
                    end else if (!bus_req && !bus_ack) begin
                        host_rdy <= bus_rw;
                        phase    <= bus_rw ? PH_RDH : PH_ALO;
                    end
                end
                PH_RDH: begin
                    if (rd_n) begin
                        host_rdy <= 1'b0;
                        phase    <= PH_ALO;
                    end
                end
                default: phase <= PH_ALO;
            endcase
        end
    end

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_req);
    p_req_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> $past(bus_ack));
    p_wr_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_rw) |-> host_rdy);
    p_rd_notrdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_rw) |-> !host_rdy);
    p_rdh_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hold |-> $stable(rdata));
endmodule

// File: rtl/hb_bridge.sv
// Top of the host-to-bus bridge: strobe edge detection, status registers,
// transaction sequencer, byte-lane enables and host port read mux.
// Assumes host strobes and command select are synchronous to clk.
module hb_bridge
    import hb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IPL_W  = 3,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_sel,
    input  logic [DATA_W-1:0] port_in,
    output logic [DATA_W-1:0] port_out,
    output logic              port_oe,
    input  logic              wr_n,
    input  logic              rd_n,
    output logic              host_rdy,
    input  logic [IPL_W-1:0]  irq_level,
    output logic              irq_pend_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rw,
    output logic              bus_uds_n,
    output logic              bus_lds_n,
    output logic              bus_req,
    input  logic              bus_ack
);
    localparam int STAT_PAD = DATA_W - IPL_W;

    logic [1:0]        fall;
    logic              wr_fall, rd_fall, stat_cmd, soft_rst, seq_rst_n;
    logic              rd_hold, byte_op;
    logic [IPL_W-1:0]  ipl_q;
    logic [DATA_W-1:0] rdata;

    hb_strobe_edge #(.N(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb_n ({rd_n, wr_n}),
        .fall   (fall)
    );
    assign wr_fall  = fall[0];
    assign rd_fall  = fall[1];
    assign stat_cmd = (cmd_sel == CMD_STAT);

    hb_status_regs #(.IPL_W(IPL_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_cmd   (stat_cmd),
        .wr_fall    (wr_fall),
        .soft_bit   (port_in[0]),
        .irq_level  (irq_level),
        .ipl_q      (ipl_q),
        .irq_pend_n (irq_pend_n),
        .soft_rst   (soft_rst)
    );

    assign seq_rst_n = rst_n && !soft_rst;

    hb_txn_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (seq_rst_n),
        .cmd_sel   (cmd_sel),
        .port_in   (port_in),
        .wr_fall   (wr_fall),
        .rd_fall   (rd_fall),
        .rd_n      (rd_n),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .rd_hold   (rd_hold),
        .host_rdy  (host_rdy),
        .bus_req   (bus_req),
        .bus_rw    (bus_rw),
        .byte_op   (byte_op),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (rdata)
    );

    // Lane enables: word uses both lanes, byte picks by address bit 0.
    always_comb begin
        bus_uds_n = !(bus_req && (!byte_op || !bus_addr[0]));
        bus_lds_n = !(bus_req && (!byte_op ||  bus_addr[0]));
    end

    // Host port return path: status word or fetched load word.
    always_comb begin
        port_oe  = !rd_n && (stat_cmd || rd_hold);
        port_out = stat_cmd ? {ipl_q, {STAT_PAD{1'b0}}} : rdata;
    end

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> $stable(bus_addr));
    p_soft_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !bus_req);
endmodule

// File: tb/hb_bridge_tb_top.sv
module hb_bridge_tb_top;
    import hb_pkg::*;

    localparam int ACK_DLY = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  cmd_sel;
    logic [15:0] port_in;
    logic [15:0] port_out;
    logic        port_oe;
    logic        wr_n, rd_n;
    logic        host_rdy;
    logic [2:0]  irq_level;
    logic        irq_pend_n;
    logic [31:0] bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        bus_rw, bus_uds_n, bus_lds_n, bus_req, bus_ack;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit mon_on = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [15:0] rd_fn(logic [31:0] a);
        return a[15:0] ^ a[31:16] ^ 16'h3C5A;
    endfunction

    assign bus_rdata = rd_fn(bus_addr);

    hb_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_sel(cmd_sel), .port_in(port_in),
        .port_out(port_out), .port_oe(port_oe), .wr_n(wr_n), .rd_n(rd_n),
        .host_rdy(host_rdy), .irq_level(irq_level), .irq_pend_n(irq_pend_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rw(bus_rw), .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n),
        .bus_req(bus_req), .bus_ack(bus_ack)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Bus slave: acknowledges after a delay, records what it saw.
    int          ack_cnt;
    int          cap_n;
    logic [31:0] cap_addr;
    logic [15:0] cap_wdata;
    logic        cap_rw, cap_uds, cap_lds;
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 1'b0;
            ack_cnt <= 0;
            cap_n   <= 0;
        end else if (bus_req && !bus_ack) begin
            if (ack_cnt >= ACK_DLY) begin
                bus_ack   <= 1'b1;
                cap_addr  <= bus_addr;
                cap_wdata <= bus_wdata;
                cap_rw    <= bus_rw;
                cap_uds   <= bus_uds_n;
                cap_lds   <= bus_lds_n;
                cap_n     <= cap_n + 1;
            end else begin
                ack_cnt <= ack_cnt + 1;
            end
        end else if (!bus_req) begin
            bus_ack <= 1'b0;
            ack_cnt <= 0;
        end
    end

    // Reference model for the pending flag, compared every clock.
    logic exp_pend;
    always @(posedge clk) begin
        if (!rst_n) exp_pend <= 1'b1;
        else        exp_pend <= (irq_level == 3'd0);
    end
    always @(negedge clk) begin
        if (mon_on) begin
            chk("R10", "irq_pend_n per clock", {31'd0, irq_pend_n}, {31'd0, exp_pend});
            if (!bus_req)
                chk("R7", "idle lane enables", {30'd0, bus_uds_n, bus_lds_n}, 32'd3);
        end
    end

    task automatic set_cmd(logic [2:0] c);
        @(negedge clk);
        cmd_sel = c;
        @(negedge clk);
    endtask

    task automatic pulse_wr(logic [15:0] w);
        port_in = w;
        wr_n    = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_write(logic [2:0] c, logic [31:0] a, logic [15:0] d,
                            logic eu, logic el);
        int  n0;
        bit  seen_ack;
        set_cmd(c);
        n0 = cap_n;
        pulse_wr(a[15:0]);
        pulse_wr(a[31:16]);
        chk("R4", "no request before data", {31'd0, bus_req}, 32'd0);
        port_in = d;
        wr_n    = 1'b0;
        @(negedge clk);
        chk("R4", "request after data strobe", {31'd0, bus_req}, 32'd1);
        chk("R4", "busy after data strobe", {31'd0, host_rdy}, 32'd1);
        wr_n = 1'b1;
        seen_ack = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (host_rdy === 1'b0) break;
            if (bus_ack === 1'b1 && !seen_ack) begin
                seen_ack = 1'b1;
                chk("R5", "busy held while ack high", {31'd0, host_rdy}, 32'd1);
            end
            @(negedge clk);
        end
        chk("R5", "ack seen before ready drop", {31'd0, seen_ack}, 32'd1);
        chk("R5", "req low at ready drop", {31'd0, bus_req}, 32'd0);
        chk("R5", "ack low at ready drop", {31'd0, bus_ack}, 32'd0);
        chk("R3", "store address", cap_addr, a);
        chk("R4", "store data", {16'd0, cap_wdata}, {16'd0, d});
        chk("R2", "store direction", {31'd0, cap_rw}, 32'd0);
        chk("R7", "store lanes", {30'd0, cap_uds, cap_lds}, {30'd0, eu, el});
        chk("R4", "one bus cycle", cap_n, n0 + 1);
    endtask

    task automatic read_phase(logic [31:0] a, logic eu, logic el);
        idle(2);
        chk("R6", "no load before read strobe", {31'd0, bus_req}, 32'd0);
        chk("R6", "port idle before read strobe", {31'd0, port_oe}, 32'd0);
        rd_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 100; i++) begin
            if (host_rdy === 1'b1) break;
            @(negedge clk);
        end
        chk("R6", "ready after load", {31'd0, host_rdy}, 32'd1);
        chk("R6", "port driven", {31'd0, port_oe}, 32'd1);
        chk("R6", "load word", {16'd0, port_out}, {16'd0, rd_fn(a)});
        chk("R6", "load direction", {31'd0, cap_rw}, 32'd1);
        chk("R3", "load address", cap_addr, a);
        chk("R7", "load lanes", {30'd0, cap_uds, cap_lds}, {30'd0, eu, el});
        rd_n = 1'b1;
        #1;
        chk("R6", "port released", {31'd0, port_oe}, 32'd0);
        @(negedge clk);
        chk("R6", "ready drops after release", {31'd0, host_rdy}, 32'd0);
    endtask

    task automatic do_read(logic [2:0] c, logic [31:0] a, logic eu, logic el);
        set_cmd(c);
        pulse_wr(a[15:0]);
        pulse_wr(a[31:16]);
        read_phase(a, eu, el);
    endtask

    task automatic stat_read(logic [15:0] exp, string tag);
        rd_n = 1'b0;
        #1;
        chk(tag, "status port enable", {31'd0, port_oe}, 32'd1);
        chk(tag, "status word", {16'd0, port_out}, {16'd0, exp});
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        begin : watchdog
            #(20ns * 100000);
            if (!done) begin
                checks++;
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int n0;
        rst_n = 1'b0; cmd_sel = CMD_WR16; port_in = 16'h0;
        wr_n = 1'b1; rd_n = 1'b1; irq_level = 3'd0;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "host_rdy", {31'd0, host_rdy}, 32'd0);
        chk("R1", "bus_req", {31'd0, bus_req}, 32'd0);
        chk("R1", "port_oe", {31'd0, port_oe}, 32'd0);
        chk("R1", "lanes", {30'd0, bus_uds_n, bus_lds_n}, 32'd3);
        chk("R1", "irq_pend_n", {31'd0, irq_pend_n}, 32'd1);
        mon_on = 1'b1;

        // R2 R3 R4 R5 R7 word store, byte stores on both lanes
        do_write(CMD_WR16, 32'h0012_3456, 16'hBEEF, 1'b0, 1'b0);
        do_write(CMD_WR8,  32'h0000_1000, 16'h5A5A, 1'b0, 1'b1);
        do_write(CMD_WR8,  32'h00A0_1001, 16'h005A, 1'b1, 1'b0);

        // R6 word load, byte loads
        do_read(CMD_RD16, 32'h0000_2468, 1'b0, 1'b0);
        do_read(CMD_RD8,  32'h00BF_E001, 1'b1, 1'b0);
        do_read(CMD_RD8,  32'h0001_0010, 1'b0, 1'b1);

        // R11 stray strobes
        set_cmd(CMD_RD16);
        rd_n = 1'b0;
        @(negedge clk);
        chk("R11", "stray read strobe port", {31'd0, port_oe}, 32'd0);
        rd_n = 1'b1;
        idle(3);
        chk("R11", "stray read strobe request", {31'd0, bus_req}, 32'd0);
        pulse_wr(16'h0044);
        pulse_wr(16'h0077);
        pulse_wr(16'hFFFF);
        idle(3);
        chk("R11", "stray write in load wait", {31'd0, bus_req}, 32'd0);
        read_phase(32'h0077_0044, 1'b0, 1'b0);

        // R12 command change restarts the sequence
        set_cmd(CMD_WR16);
        pulse_wr(16'h1111);
        do_write(CMD_WR8, 32'h0000_0003, 16'h00C3, 1'b1, 1'b0);

        // R2 reserved code ignores strobes
        set_cmd(3'b101);
        n0 = cap_n;
        pulse_wr(16'h0001);
        pulse_wr(16'h0002);
        pulse_wr(16'h0003);
        rd_n = 1'b0;
        @(negedge clk);
        chk("R2", "reserved code port", {31'd0, port_oe}, 32'd0);
        rd_n = 1'b1;
        idle(6);
        chk("R2", "reserved code request", {31'd0, bus_req}, 32'd0);
        chk("R2", "reserved code no cycle", cap_n, n0);

        // R8 R10 status word and pending flag
        irq_level = 3'd5;
        idle(2);
        chk("R10", "pending on level 5", {31'd0, irq_pend_n}, 32'd0);
        set_cmd(CMD_STAT);
        stat_read(16'hA000, "R8");
        irq_level = 3'd7;
        idle(2);
        stat_read(16'hE000, "R8");
        irq_level = 3'd1;
        idle(2);
        stat_read(16'h2000, "R8");
        irq_level = 3'd0;
        idle(2);
        chk("R10", "pending clear on level 0", {31'd0, irq_pend_n}, 32'd1);
        stat_read(16'h0000, "R8");

        // R9 soft reset holds the sequencer
        pulse_wr(16'h0001);
        set_cmd(CMD_WR16);
        n0 = cap_n;
        pulse_wr(16'h0100);
        pulse_wr(16'h0000);
        pulse_wr(16'h1234);
        idle(6);
        chk("R9", "no request in soft reset", {31'd0, bus_req}, 32'd0);
        chk("R9", "no ready in soft reset", {31'd0, host_rdy}, 32'd0);
        chk("R9", "no cycle in soft reset", cap_n, n0);
        set_cmd(CMD_STAT);
        pulse_wr(16'h0000);
        do_write(CMD_WR16, 32'h0033_0100, 16'h4321, 1'b0, 1'b0);

        idle(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule